// File: doc/BRIEF.md
# Strap Capture and Frequency Select

This block takes a handful of board-level strap pins and freezes them once, early in power-up, so the clock core has a fixed configuration. Three frequency-select straps and one debug-clock strap are synchronized and filtered. They are captured on the first occasion that the active-low power-good input is seen low while the strap bus has been steady. After capture the block publishes the 3-bit select and the debug-clock select. It also publishes decoded rate codes for the CPU, SRC, PCI and DOT clock domains, and drive enables for the output stage.

Once captured, the configuration is locked. Later activity on power-good or on the strap pins changes nothing until the next power-on reset, which re-arms the capture. Before capture every rate code reads as off, and the pin that doubles as a strap and a free-running PCI clock output keeps its driver disabled. This lets the strap be read without contention.

Top module: `strap_latch_top`

## Requirements
- R1: During and right after reset, `ready`=0, `pcif0_oe`=0, `fs_sel`=3'b001, `itp_sel`=0, `cpu_code`=7 (off), and `src_code`, `pci_code` and `dot_code` are all 2'b00 (off).
- R2: While the synchronized `pwrgd_n` stays high, no capture happens and `ready` stays 0.
- R3: Suppose the straps have been steady for several cycles. When `pwrgd_n` falls, `ready` is still 0 after the second rising clock edge and is 1 after the third. `fs_sel` then holds the captured straps, with bit 0 from the A strap, bit 1 from B and bit 2 from C.
- R4: While `ready`=1, `cpu_code` decodes `fs_sel` as follows: 000→4, 001→1, 010→3, 011→2, 100→5, 101→0, 110→6, 111→3. The codes stand for 0=100, 1=133.33, 2=166.66, 3=200, 4=266.66, 5=333.33 and 6=400 MHz; 7 means off.
- R5: While `ready`=1, `src_code` (100 MHz), `pci_code` (33.33 MHz) and `dot_code` (96 MHz) each read 2'b01 for every select value. While `ready`=0 they read 2'b00.
- R6: After capture, `itp_sel` equals the captured debug-clock strap: 1 routes the CPU debug clock, 0 routes the eighth SRC clock.
- R7: `pcif0_oe` is 0 until capture and 1 from the capture cycle on.
- R8: After capture, further toggling of `pwrgd_n` and changes on any strap pin leave `ready`, `fs_sel` and `itp_sel` unchanged until reset.
- R9: If the synchronized strap bus changes on every cycle, capture is held off even with `pwrgd_n` low. Capture takes place once the bus holds one value for two consecutive sampled cycles, and that value is the one captured.
- R10: Reset re-arms the capture. If `pwrgd_n` is already low while reset is applied, capture follows the release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| fs_strap | input | 3 | Frequency-select strap pins, bit 0 = A, bit 1 = B, bit 2 = C |
| itp_strap | input | 1 | Debug-clock select strap pin |
| pwrgd_n | input | 1 | Active-low power-good; low means the straps are valid |
| fs_sel | output | 3 | Captured frequency select |
| itp_sel | output | 1 | Captured debug-clock select |
| ready | output | 1 | Capture done; clock outputs may run |
| pcif0_oe | output | 1 | Driver enable for the strap pin that becomes a PCI clock |
| cpu_code | output | 3 | CPU rate code (7 = off) |
| src_code | output | 2 | SRC rate code (01 = 100 MHz, 00 = off) |
| pci_code | output | 2 | PCI rate code (01 = 33.33 MHz, 00 = off) |
| dot_code | output | 2 | DOT rate code (01 = 96 MHz, 00 = off) |

## Verification
Every one of the eight select values is captured in its own power cycle, with the debug strap alternating between cycles. This separates a swapped or mis-decoded CPU entry, and a swapped bit order of the straps, from a correct table. Each cycle then flips all straps and pulses power-good again after capture, which exposes any re-sampling. A strap bus that toggles on every cycle under a low power-good tells a working stability filter apart from a missing one. Holding power-good low through reset shows that reset alone re-arms the capture.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int FS_W = 3;

    typedef enum logic [2:0] {
        CPU_100  = 3'd0,
        CPU_133  = 3'd1,
        CPU_166  = 3'd2,
        CPU_200  = 3'd3,
        CPU_266  = 3'd4,
        CPU_333  = 3'd5,
        CPU_400  = 3'd6,
        CPU_OFF  = 3'd7
    } cpu_code_e;

    typedef enum logic [1:0] {
        AUX_OFF  = 2'd0,
        AUX_RUN  = 2'd1
    } aux_code_e;

    typedef struct packed {
        logic            itp;
        logic [FS_W-1:0] fs;
    } strap_t;

    localparam int STRAP_W = $bits(strap_t);

    // Values the pads settle to when nothing drives them (A pulled up).
    localparam strap_t STRAP_IDLE = '{itp: 1'b0, fs: 3'b001};

    function automatic cpu_code_e cpu_rate(input logic [FS_W-1:0] sel);
        cpu_code_e r;
        case (sel)
            3'b000:  r = CPU_266;
            3'b001:  r = CPU_133;
            3'b010:  r = CPU_200;
            3'b011:  r = CPU_166;
            3'b100:  r = CPU_333;
            3'b101:  r = CPU_100;
            3'b110:  r = CPU_400;
            default: r = CPU_200;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = WIDTH * STAGES;

    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] r;
            always_ff @(posedge clk) begin
                if (rst) r <= RST_VAL;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [CHAIN_W-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= {STAGES{RST_VAL}};
                else     sh <= {sh[CHAIN_W-WIDTH-1:0], d};
            end
            assign q = sh[CHAIN_W-1 -: WIDTH];
        end
    endgenerate

endmodule

// File: rtl/strap_stable.sv
module strap_stable #(
    parameter int          WIDTH         = 4,
    parameter int          STABLE_CYCLES = 2,
    parameter logic [WIDTH-1:0] RST_VAL  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic             stable
);
    localparam int CNT_MAX = (STABLE_CYCLES > 1) ? STABLE_CYCLES - 1 : 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    generate
        if (STABLE_CYCLES <= 1) begin : g_nofilter
            assign stable = 1'b1;
            logic [WIDTH:0] unused_in;
            assign unused_in = {clk, rst, d} == '0 ? '0 : '0;
        end else begin : g_filter
            logic [WIDTH-1:0] prev;
            logic [CNT_W-1:0] run;
            logic [CNT_W-1:0] run_next;

            always_comb begin
                if (d != prev)                      run_next = '0;
                else if (run == CNT_W'(CNT_MAX))    run_next = run;
                else                                run_next = run + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev <= RST_VAL;
                    run  <= '0;
                end else begin
                    prev <= d;
                    run  <= run_next;
                end
            end

            assign stable = (run_next >= CNT_W'(CNT_MAX));

            // R9: a value just changed cannot be called steady
            a_r9_change_not_stable: assert property (@(posedge clk) disable iff (rst)
                (d != prev) |-> !stable);
        end
    endgenerate

endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  strap_t strap_s,
    input  logic   strap_steady,
    input  logic   pwr_low_s,
    output strap_t cap,
    output logic   locked
);
    typedef enum logic [0:0] { ST_ARMED = 1'b0, ST_LOCKED = 1'b1 } cap_state_e;

    cap_state_e state;
    logic       fire;

    assign fire = (state == ST_ARMED) && pwr_low_s && strap_steady;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ARMED;
            cap   <= STRAP_IDLE;
        end else if (fire) begin
            state <= ST_LOCKED;
            cap   <= strap_s;
        end
    end

    assign locked = (state == ST_LOCKED);

    // R8: once locked, stay locked with a frozen value
    a_r8_hold_lock: assert property (@(posedge clk) disable iff (rst)
        locked |=> (locked && $stable(cap)));

    // R2: no capture without power-good
    a_r2_need_pwrgd: assert property (@(posedge clk) disable iff (rst)
        (!locked && !pwr_low_s) |=> !locked);

    // R9: no capture while the strap bus is moving
    a_r9_need_steady: assert property (@(posedge clk) disable iff (rst)
        (!locked && !strap_steady) |=> !locked);

endmodule

// File: rtl/freq_decode.sv
module freq_decode
    import strap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [FS_W-1:0] sel,
    output cpu_code_e       cpu_code,
    output aux_code_e       src_code,
    output aux_code_e       pci_code,
    output aux_code_e       dot_code
);
    always_comb begin
        if (en) begin
            cpu_code = cpu_rate(sel);
            src_code = AUX_RUN;
            pci_code = AUX_RUN;
            dot_code = AUX_RUN;
        end else begin
            cpu_code = CPU_OFF;
            src_code = AUX_OFF;
            pci_code = AUX_OFF;
            dot_code = AUX_OFF;
        end
    end

    // R4: an enabled core never sees the off code
    a_r4_cpu_running: assert property (@(posedge clk) disable iff (rst)
        en |-> (cpu_code != CPU_OFF));

    // R5: the fixed-rate domains run together and only when enabled
    a_r5_aux_fixed: assert property (@(posedge clk) disable iff (rst)
        (src_code == pci_code) && (pci_code == dot_code) && ((src_code == AUX_RUN) == en));

endmodule

// File: rtl/strap_latch_top.sv
module strap_latch_top
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] fs_strap,
    input  logic       itp_strap,
    input  logic       pwrgd_n,
    output logic [2:0] fs_sel,
    output logic       itp_sel,
    output logic       ready,
    output logic       pcif0_oe,
    output logic [2:0] cpu_code,
    output logic [1:0] src_code,
    output logic [1:0] pci_code,
    output logic [1:0] dot_code
);
    strap_t    strap_raw;
    strap_t    strap_s;
    logic      pwrgd_n_s;
    logic      steady;
    strap_t    cap;
    logic      locked;
    cpu_code_e cpu_e;
    aux_code_e src_e, pci_e, dot_e;

    assign strap_raw = '{itp: itp_strap, fs: fs_strap};

    strap_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES), .RST_VAL(STRAP_IDLE)) u_sync_strap (
        .clk (clk),
        .rst (rst),
        .d   (strap_raw),
        .q   (strap_s)
    );

    strap_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pwr (
        .clk (clk),
        .rst (rst),
        .d   (pwrgd_n),
        .q   (pwrgd_n_s)
    );

    strap_stable #(.WIDTH(STRAP_W), .STABLE_CYCLES(STABLE_CYCLES), .RST_VAL(STRAP_IDLE)) u_stable (
        .clk    (clk),
        .rst    (rst),
        .d      (strap_s),
        .stable (steady)
    );

    strap_capture u_cap (
        .clk          (clk),
        .rst          (rst),
        .strap_s      (strap_s),
        .strap_steady (steady),
        .pwr_low_s    (!pwrgd_n_s),
        .cap          (cap),
        .locked       (locked)
    );

    freq_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .en       (locked),
        .sel      (cap.fs),
        .cpu_code (cpu_e),
        .src_code (src_e),
        .pci_code (pci_e),
        .dot_code (dot_e)
    );

    assign fs_sel   = cap.fs;
    assign itp_sel  = cap.itp;
    assign ready    = locked;
    assign pcif0_oe = locked;
    assign cpu_code = cpu_e;
    assign src_code = src_e;
    assign pci_code = pci_e;
    assign dot_code = dot_e;

    // R3: capture happens only after power-good was seen low
    a_r3_rise_after_pwrgd: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(!pwrgd_n_s));

    // R7: the shared pin driver never turns off again without reset
    a_r7_oe_sticky: assert property (@(posedge clk) disable iff (rst)
        pcif0_oe |=> pcif0_oe);

endmodule

// File: tb/strap_latch_top_test.sv
module strap_latch_top_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] fs_strap;
    logic       itp_strap;
    logic       pwrgd_n;
    logic [2:0] fs_sel;
    logic       itp_sel;
    logic       ready;
    logic       pcif0_oe;
    logic [2:0] cpu_code;
    logic [1:0] src_code;
    logic [1:0] pci_code;
    logic [1:0] dot_code;

    always #5 clk = ~clk;

    strap_latch_top uut (
        .clk(clk), .rst(rst), .fs_strap(fs_strap), .itp_strap(itp_strap),
        .pwrgd_n(pwrgd_n), .fs_sel(fs_sel), .itp_sel(itp_sel), .ready(ready),
        .pcif0_oe(pcif0_oe), .cpu_code(cpu_code), .src_code(src_code),
        .pci_code(pci_code), .dot_code(dot_code)
    );

    typedef struct { logic [2:0] fs; logic itp; } exp_t;
    exp_t exp_q[$];

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic logic [2:0] exp_cpu(input logic [2:0] s);
        case (s)
            3'd0: return 3'd4;
            3'd1: return 3'd1;
            3'd2: return 3'd3;
            3'd3: return 3'd2;
            3'd4: return 3'd5;
            3'd5: return 3'd0;
            3'd6: return 3'd6;
            default: return 3'd3;
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: on each capture, pop the expected straps and compare all outputs
    logic ready_q = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            ready_q = 1'b0;
        end else begin
            if (ready && !ready_q) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected capture", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(fs_sel == e.fs, "R3 fs_sel", fs_sel, e.fs);
                    chk(itp_sel == e.itp, "R6 itp_sel", itp_sel, e.itp);
                    chk(cpu_code == exp_cpu(e.fs), "R4 cpu_code", cpu_code, exp_cpu(e.fs));
                    chk(src_code == 2'b01, "R5 src_code", src_code, 1);
                    chk(pci_code == 2'b01, "R5 pci_code", pci_code, 1);
                    chk(dot_code == 2'b01, "R5 dot_code", dot_code, 1);
                    chk(pcif0_oe == 1'b1, "R7 pcif0_oe", pcif0_oe, 1);
                end
            end
            ready_q = ready;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic check_reset_state();
        chk(ready == 1'b0, "R1 ready", ready, 0);
        chk(pcif0_oe == 1'b0, "R1 pcif0_oe", pcif0_oe, 0);
        chk(fs_sel == 3'b001, "R1 fs_sel", fs_sel, 1);
        chk(itp_sel == 1'b0, "R1 itp_sel", itp_sel, 0);
        chk(cpu_code == 3'd7, "R1 cpu_code", cpu_code, 7);
        chk({src_code, pci_code, dot_code} == 6'd0, "R1 aux codes", {src_code, pci_code, dot_code}, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
    endtask

    task automatic trial(input logic [2:0] fs, input logic itp);
        exp_t e;
        fs_strap  = fs;
        itp_strap = itp;
        pwrgd_n   = 1'b1;
        do_reset();
        repeat (6) @(negedge clk);
        chk(ready == 1'b0, "R2 ready with pwrgd high", ready, 0);
        chk(pcif0_oe == 1'b0, "R7 oe before capture", pcif0_oe, 0);
        e.fs = fs; e.itp = itp;
        exp_q.push_back(e);
        pwrgd_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(ready == 1'b0, "R3 ready after 2 edges", ready, 0);
        @(negedge clk);
        chk(ready == 1'b1, "R3 ready after 3 edges", ready, 1);
        // R8: disturb straps and power-good after capture
        fs_strap  = ~fs;
        itp_strap = ~itp;
        pwrgd_n   = 1'b1;
        repeat (4) @(negedge clk);
        pwrgd_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(ready == 1'b1, "R8 ready held", ready, 1);
        chk(fs_sel == fs, "R8 fs_sel frozen", fs_sel, fs);
        chk(itp_sel == itp, "R8 itp_sel frozen", itp_sel, itp);
        chk(cpu_code == exp_cpu(fs), "R8 cpu_code frozen", cpu_code, exp_cpu(fs));
    endtask

    initial begin
        exp_t e;
        rst       = 1'b1;
        pwrgd_n   = 1'b1;
        fs_strap  = 3'b001;
        itp_strap = 1'b0;

        for (int i = 0; i < 8; i++) begin
            trial(3'(i), i[0]);
        end

        // R9: a moving strap bus blocks capture
        fs_strap  = 3'b010;
        itp_strap = 1'b0;
        pwrgd_n   = 1'b1;
        do_reset();
        repeat (6) @(negedge clk);
        pwrgd_n = 1'b0;
        for (int k = 0; k < 12; k++) begin
            fs_strap  = (k % 2 == 0) ? 3'b101 : 3'b010;
            itp_strap = k[0];
            @(negedge clk);
        end
        chk(ready == 1'b0, "R9 no capture while toggling", ready, 0);
        e.fs = 3'b110; e.itp = 1'b1;
        exp_q.push_back(e);
        fs_strap  = 3'b110;
        itp_strap = 1'b1;
        repeat (8) @(negedge clk);
        chk(ready == 1'b1, "R9 capture once held", ready, 1);
        chk(fs_sel == 3'b110, "R9 captured held value", fs_sel, 6);

        // R10: power-good low through reset, capture after release
        fs_strap  = 3'b011;
        itp_strap = 1'b1;
        pwrgd_n   = 1'b0;
        e.fs = 3'b011; e.itp = 1'b1;
        exp_q.push_back(e);
        do_reset();
        repeat (8) @(negedge clk);
        chk(ready == 1'b1, "R10 capture after reset", ready, 1);
        chk(fs_sel == 3'b011, "R10 fs_sel", fs_sel, 3);
        chk(cpu_code == 3'd2, "R10 cpu_code", cpu_code, 2);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all captures seen", exp_q.size(), 0);
        finish_run();
    end

endmodule